// File: doc/BRIEF.md
# Interrupt state save/restore controller

This block holds the two machine-state bits that govern exception handling in a processor core: the external-interrupt enable (EE) and the recoverable-interrupt flag (RI). It also holds a parameterised group of further state bits that travel with them, the shadow copies of all these bits in save/restore register 1 (SRR1), and the return address in save/restore register 0 (SRR0). When the core takes an interrupt, the block saves the live bits and the return address, then clears EE and RI. A return-from-interrupt command copies the shadows back and sends the saved address to fetch as the next address.

Software changes the bits in two ways. A move-to-state write loads all live bits at once. Three special command registers each apply a fixed operation to EE and RI, and the data written to them is ignored. A read of any of those three registers returns nothing and instead raises a software emulation trap request. Because the recoverable flag is cleared on entry and is set again only by the handler, an interrupt that arrives while the save registers still hold live state records a shadow RI of 0. The handler reads that 0 as "not restartable".

Top module: `exc_state_ctl`

## Requirements
- R1: When `exc_take` is high at a clock edge, `srr1_ri` takes the value `msr_ri` had before that edge, and `msr_ri` becomes 0 after the edge.
- R2: When `exc_take` is high at a clock edge, `srr1_ee` takes the value `msr_ee` had before that edge, `msr_ee` becomes 0, and `srr1_xbits` takes `msr_xbits`. `msr_xbits` itself is left unchanged.
- R3: A `rfi_req` without `exc_take` loads `msr_ee`, `msr_ri` and `msr_xbits` from `srr1_ee`, `srr1_ri` and `srr1_xbits` on the next edge.
- R4: A `msr_wr_en` write, when neither `exc_take` nor `rfi_req` is high, loads `msr_ee`, `msr_ri` and `msr_xbits` from `msr_wr_ee`, `msr_wr_ri` and `msr_wr_xbits` on the next edge.
- R5: A `cmd_wr_en` write, when no interrupt entry, return or move-to-state write is present, acts on the next edge according to `cmd_sel`:
  - 0 sets both EE and RI.
  - 1 clears EE and leaves RI unchanged.
  - 2 clears both bits.
  - 3 changes nothing.
  
  `cmd_wdata` has no effect in any case.
- R6: A `cmd_rd_en` read with `cmd_sel` 0, 1 or 2 makes `emul_trap` high for exactly the next cycle and changes no state. A read with `cmd_sel` 3, or no read at all, leaves `emul_trap` low.
- R7: An interrupt taken while `msr_ri` is 0 overwrites SRR0 and SRR1 and stores 0 in `srr1_ri`, which marks it as not restartable.
- R8: On interrupt entry, `srr0_pc` captures `exc_ret_pc`. On the cycle after a `rfi_req` that has no `exc_take`, `redir_vld` is high and `redir_pc` holds the `srr0_pc` value that was present at the request.
- R9: The fixed priority is interrupt entry, then return, then move-to-state write, then command write. An interrupt entry in the same cycle as a move-to-state write leaves EE and RI cleared.
- R10: After reset, all live bits, all shadow bits, `srr0_pc`, `redir_vld`, `redir_pc` and `emul_trap` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| exc_take | input | 1 | Interrupt taken this cycle |
| exc_ret_pc | input | ADDR_W | Return address to save in SRR0 |
| rfi_req | input | 1 | Return-from-interrupt command |
| msr_wr_en | input | 1 | Move-to-state write strobe |
| msr_wr_ee | input | 1 | EE value for the move-to-state write |
| msr_wr_ri | input | 1 | RI value for the move-to-state write |
| msr_wr_xbits | input | XBITS | Further state bits for the move-to-state write |
| cmd_wr_en | input | 1 | Special command register write strobe |
| cmd_rd_en | input | 1 | Special command register read strobe |
| cmd_sel | input | 2 | Command register select (0 set both, 1 clear EE, 2 clear both, 3 none) |
| cmd_wdata | input | DATA_W | Command write data (ignored) |
| msr_ee | output | 1 | Live external-interrupt enable |
| msr_ri | output | 1 | Live recoverable-interrupt flag |
| msr_xbits | output | XBITS | Live further state bits |
| srr1_ee | output | 1 | Saved EE |
| srr1_ri | output | 1 | Saved RI |
| srr1_xbits | output | XBITS | Saved further state bits |
| srr0_pc | output | ADDR_W | Saved return address |
| redir_vld | output | 1 | Fetch redirect strobe after a return |
| redir_pc | output | ADDR_W | Fetch redirect address |
| emul_trap | output | 1 | Software emulation trap request |

## Verification
The bench builds the block with an 8-bit return address, two further state bits and an 8-bit command data bus. With this configuration it can walk every starting combination of EE, RI and the further bits through every command select, for both reads and writes. It also takes an interrupt and a nested interrupt from each starting state. A second sweep covers all sixteen combinations of the four competing strobes, which exercises every branch of the priority order. Expected values come from a small model in the bench that is written from the requirements.

// File: rtl/exc_state_pkg.sv
package exc_state_pkg;

   typedef enum logic [1:0] {
      CMD_SET_BOTH = 2'd0,
      CMD_CLR_EE   = 2'd1,
      CMD_CLR_BOTH = 2'd2,
      CMD_NONE     = 2'd3
   } cmd_sel_e;

   typedef struct packed {
      logic ee;
      logic ri;
   } ctl_bits_t;

   typedef struct packed {
      logic set_ee;
      logic set_ri;
      logic clr_ee;
      logic clr_ri;
   } bit_op_t;

endpackage

// File: rtl/exc_cmd_decode.sv
module exc_cmd_decode
   import exc_state_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      cmd_wr_en,
   input  logic      cmd_rd_en,
   input  logic [1:0] cmd_sel,
   output logic      op_vld,
   output bit_op_t   op,
   output logic      trap_q
);

   cmd_sel_e sel;
   logic     sel_hit;

   assign sel     = cmd_sel_e'(cmd_sel);
   assign sel_hit = (sel != CMD_NONE);

   always_comb begin
      op = '0;
      unique case (sel)
         CMD_SET_BOTH: begin op.set_ee = 1'b1; op.set_ri = 1'b1; end
         CMD_CLR_EE:   begin op.clr_ee = 1'b1; end
         CMD_CLR_BOTH: begin op.clr_ee = 1'b1; op.clr_ri = 1'b1; end
         default:      op = '0;
      endcase
   end

   assign op_vld = cmd_wr_en && sel_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trap_q <= 1'b0;
      else        trap_q <= cmd_rd_en && sel_hit;
   end

endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
   import exc_state_pkg::*;
#(
   parameter int XBITS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             rfi,
   input  logic             mwr,
   input  ctl_bits_t        mwr_bits,
   input  logic [XBITS-1:0] mwr_x,
   input  logic             op_vld,
   input  bit_op_t          op,
   output ctl_bits_t        live,
   output logic [XBITS-1:0] live_x,
   output ctl_bits_t        shad,
   output logic [XBITS-1:0] shad_x
);

   ctl_bits_t live_d;

   always_comb begin
      live_d = live;
      if (take) begin
         live_d = '0;
      end else if (rfi) begin
         live_d = shad;
      end else if (mwr) begin
         live_d = mwr_bits;
      end else if (op_vld) begin
         if (op.set_ee) live_d.ee = 1'b1;
         if (op.set_ri) live_d.ri = 1'b1;
         if (op.clr_ee) live_d.ee = 1'b0;
         if (op.clr_ri) live_d.ri = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live <= '0;
         shad <= '0;
      end else begin
         live <= live_d;
         if (take) shad <= live;
      end
   end

   for (genvar i = 0; i < XBITS; i++) begin : g_xbit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            live_x[i] <= 1'b0;
            shad_x[i] <= 1'b0;
         end else if (take) begin
            shad_x[i] <= live_x[i];
         end else if (rfi) begin
            live_x[i] <= shad_x[i];
         end else if (mwr) begin
            live_x[i] <= mwr_x[i];
         end
      end
   end

endmodule

// File: rtl/exc_ret_addr.sv
module exc_ret_addr #(
   parameter int ADDR_W    = 32,
   parameter bit REDIR_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              rfi,
   input  logic [ADDR_W-1:0] ret_pc,
   output logic [ADDR_W-1:0] srr0_q,
   output logic              rd_vld,
   output logic [ADDR_W-1:0] rd_pc
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    srr0_q <= '0;
      else if (take) srr0_q <= ret_pc;
   end

   if (REDIR_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_vld <= 1'b0;
            rd_pc  <= '0;
         end else begin
            rd_vld <= rfi && !take;
            rd_pc  <= srr0_q;
         end
      end
   end else begin : g_comb
      assign rd_vld = rfi && !take;
      assign rd_pc  = srr0_q;
   end

endmodule

// File: rtl/exc_state_ctl.sv
module exc_state_ctl
   import exc_state_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int XBITS     = 2,
   parameter int DATA_W    = 32,
   parameter bit REDIR_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              exc_take,
   input  logic [ADDR_W-1:0] exc_ret_pc,
   input  logic              rfi_req,
   input  logic              msr_wr_en,
   input  logic              msr_wr_ee,
   input  logic              msr_wr_ri,
   input  logic [XBITS-1:0]  msr_wr_xbits,
   input  logic              cmd_wr_en,
   input  logic              cmd_rd_en,
   input  logic [1:0]        cmd_sel,
   input  logic [DATA_W-1:0] cmd_wdata,
   output logic              msr_ee,
   output logic              msr_ri,
   output logic [XBITS-1:0]  msr_xbits,
   output logic              srr1_ee,
   output logic              srr1_ri,
   output logic [XBITS-1:0]  srr1_xbits,
   output logic [ADDR_W-1:0] srr0_pc,
   output logic              redir_vld,
   output logic [ADDR_W-1:0] redir_pc,
   output logic              emul_trap
);

   initial begin
      if (ADDR_W < 2)  $fatal(1, "exc_state_ctl: ADDR_W must be at least 2");
      if (XBITS < 1)   $fatal(1, "exc_state_ctl: XBITS must be at least 1");
      if (DATA_W < 1)  $fatal(1, "exc_state_ctl: DATA_W must be at least 1");
   end

   logic      unused_wdata;
   logic      op_vld;
   bit_op_t   op;
   ctl_bits_t live, shad, mwr_bits;

   assign unused_wdata = ^cmd_wdata;
   assign mwr_bits     = '{ee: msr_wr_ee, ri: msr_wr_ri};

   exc_cmd_decode u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_wr_en (cmd_wr_en),
      .cmd_rd_en (cmd_rd_en),
      .cmd_sel   (cmd_sel),
      .op_vld    (op_vld),
      .op        (op),
      .trap_q    (emul_trap)
   );

   exc_state_regs #(.XBITS(XBITS)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (exc_take),
      .rfi      (rfi_req),
      .mwr      (msr_wr_en),
      .mwr_bits (mwr_bits),
      .mwr_x    (msr_wr_xbits),
      .op_vld   (op_vld),
      .op       (op),
      .live     (live),
      .live_x   (msr_xbits),
      .shad     (shad),
      .shad_x   (srr1_xbits)
   );

   exc_ret_addr #(.ADDR_W(ADDR_W), .REDIR_REG(REDIR_REG)) u_ret (
      .clk    (clk),
      .rst_n  (rst_n),
      .take   (exc_take),
      .rfi    (rfi_req),
      .ret_pc (exc_ret_pc),
      .srr0_q (srr0_pc),
      .rd_vld (redir_vld),
      .rd_pc  (redir_pc)
   );

   assign msr_ee  = live.ee;
   assign msr_ri  = live.ri;
   assign srr1_ee = shad.ee;
   assign srr1_ri = shad.ri;

endmodule

// File: rtl/exc_state_chk.sv
module exc_state_chk #(
   parameter int ADDR_W    = 32,
   parameter int XBITS     = 2,
   parameter bit REDIR_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              exc_take,
   input logic [ADDR_W-1:0] exc_ret_pc,
   input logic              rfi_req,
   input logic              msr_wr_en,
   input logic              msr_wr_ee,
   input logic              msr_wr_ri,
   input logic              cmd_wr_en,
   input logic              cmd_rd_en,
   input logic [1:0]        cmd_sel,
   input logic              msr_ee,
   input logic              msr_ri,
   input logic              srr1_ee,
   input logic              srr1_ri,
   input logic [ADDR_W-1:0] srr0_pc,
   input logic              redir_vld,
   input logic [ADDR_W-1:0] redir_pc,
   input logic              emul_trap
);

   p_entry_ri_r1: assert property (@(posedge clk) disable iff (!rst_n)
      exc_take |=> (srr1_ri == $past(msr_ri)) && !msr_ri);

   p_entry_ee_r2: assert property (@(posedge clk) disable iff (!rst_n)
      exc_take |=> (srr1_ee == $past(msr_ee)) && !msr_ee);

   p_restore_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rfi_req && !exc_take) |=> (msr_ee == $past(srr1_ee)) && (msr_ri == $past(srr1_ri)));

   p_mtmsr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (msr_wr_en && !exc_take && !rfi_req) |=>
         (msr_ee == $past(msr_wr_ee)) && (msr_ri == $past(msr_wr_ri)));

   p_cmd_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr_en && cmd_sel == 2'd0 && !exc_take && !rfi_req && !msr_wr_en) |=> msr_ee && msr_ri);

   p_cmd_clr_ee_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr_en && cmd_sel == 2'd1 && !exc_take && !rfi_req && !msr_wr_en) |=>
         !msr_ee && (msr_ri == $past(msr_ri)));

   p_trap_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_rd_en && cmd_sel != 2'd3) |=> emul_trap);

   p_trap_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_rd_en && cmd_sel != 2'd3) |=> !emul_trap);

   p_srr0_r8: assert property (@(posedge clk) disable iff (!rst_n)
      exc_take |=> srr0_pc == $past(exc_ret_pc));

   p_redir_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (REDIR_REG && rfi_req && !exc_take) |=> redir_vld && (redir_pc == $past(srr0_pc)));

   p_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_take && msr_wr_en) |=> !msr_ee && !msr_ri);

endmodule

bind exc_state_ctl exc_state_chk #(
   .ADDR_W(ADDR_W), .XBITS(XBITS), .REDIR_REG(REDIR_REG)
) u_chk (.*);

// File: tb/tb_exc_state_ctl.sv
module tb_exc_state_ctl;

   localparam int AW = 8;
   localparam int XB = 2;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          exc_take = 0, rfi_req = 0, msr_wr_en = 0, msr_wr_ee = 0, msr_wr_ri = 0;
   logic [AW-1:0] exc_ret_pc = '0;
   logic [XB-1:0] msr_wr_xbits = '0;
   logic          cmd_wr_en = 0, cmd_rd_en = 0;
   logic [1:0]    cmd_sel = '0;
   logic [DW-1:0] cmd_wdata = '0;
   logic          msr_ee, msr_ri, srr1_ee, srr1_ri, redir_vld, emul_trap;
   logic [XB-1:0] msr_xbits, srr1_xbits;
   logic [AW-1:0] srr0_pc, redir_pc;

   exc_state_ctl #(.ADDR_W(AW), .XBITS(XB), .DATA_W(DW), .REDIR_REG(1'b1)) dut (.*);

   always #4 clk = ~clk;

   int n_chk = 0, n_fail = 0;

   logic          m_ee = 0, m_ri = 0, s_ee = 0, s_ri = 0;
   logic [XB-1:0] m_x = '0, s_x = '0;
   logic [AW-1:0] s0 = '0;
   logic          e_rv = 0, e_trap = 0;
   logic [AW-1:0] e_rpc = '0;

   function automatic logic [4+2*XB+2*AW+1:0] act_vec();
      return {msr_ee, msr_ri, msr_xbits, srr1_ee, srr1_ri, srr1_xbits,
              srr0_pc, redir_vld, redir_pc, emul_trap};
   endfunction

   function automatic logic [4+2*XB+2*AW+1:0] exp_vec();
      return {m_ee, m_ri, m_x, s_ee, s_ri, s_x, s0, e_rv, e_rpc, e_trap};
   endfunction

   task automatic check(input string tag);
      n_chk++;
      if (act_vec() !== exp_vec()) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act_vec(), exp_vec());
      end
   endtask

   task automatic step(input string tag, input logic e, input logic [AW-1:0] pc,
                       input logic r, input logic mw, input logic [1:0] mb,
                       input logic [XB-1:0] mx, input logic cw, input logic cr,
                       input logic [1:0] sel, input logic [DW-1:0] d);
      exc_take = e; exc_ret_pc = pc; rfi_req = r; msr_wr_en = mw;
      msr_wr_ee = mb[1]; msr_wr_ri = mb[0]; msr_wr_xbits = mx;
      cmd_wr_en = cw; cmd_rd_en = cr; cmd_sel = sel; cmd_wdata = d;
      @(posedge clk);
      e_rv = r && !e; e_rpc = s0; e_trap = cr && (sel != 2'd3);
      if (e) begin
         s_ee = m_ee; s_ri = m_ri; s_x = m_x; s0 = pc; m_ee = 0; m_ri = 0;
      end else if (r) begin
         m_ee = s_ee; m_ri = s_ri; m_x = s_x;
      end else if (mw) begin
         m_ee = mb[1]; m_ri = mb[0]; m_x = mx;
      end else if (cw) begin
         case (sel)
            2'd0: begin m_ee = 1; m_ri = 1; end
            2'd1: m_ee = 0;
            2'd2: begin m_ee = 0; m_ri = 0; end
            default: ;
         endcase
      end
      @(negedge clk);
      check(tag);
      exc_take = 0; rfi_req = 0; msr_wr_en = 0; cmd_wr_en = 0; cmd_rd_en = 0;
   endtask

   task automatic mtmsr(input string tag, input logic [1:0] b, input logic [XB-1:0] x);
      step(tag, 0, '0, 0, 1, b, x, 0, 0, 2'd0, '0);
   endtask

   task automatic do_reset();
      rst_n = 0;
      @(negedge clk);
      m_ee = 0; m_ri = 0; s_ee = 0; s_ri = 0; m_x = '0; s_x = '0; s0 = '0;
      e_rv = 0; e_rpc = '0; e_trap = 0;
      check("R10 reset state");
      @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check("R10 after release");
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
   end

   initial begin
      @(negedge clk);
      do_reset();

      for (int st = 0; st < 4; st++) begin
         for (int xv = 0; xv < 4; xv++) begin
            mtmsr("R4 move-to-state", st[1:0], xv[XB-1:0]);
            // R5: every select, with varying data that must not matter
            for (int sl = 0; sl < 4; sl++) begin
               step("R5 command write", 0, '0, 0, 0, 2'b00, '0, 1, 0, sl[1:0],
                    DW'(st * 37 + sl * 91 + xv * 5));
               mtmsr("R4 restore", st[1:0], xv[XB-1:0]);
            end
            // R6: reads trap for selects 0..2 and leave state alone
            for (int sl = 0; sl < 4; sl++)
               step("R6 command read", 0, '0, 0, 0, 2'b00, '0, 0, 1, sl[1:0], '1);
            step("R6 trap pulse ends", 0, '0, 0, 0, 2'b00, '0, 0, 0, 2'd0, '0);
            // R1/R2 entry, then R7 nested entry with RI already 0
            step("R1 R2 interrupt entry", 1, AW'(st * 16 + xv + 3), 0, 0, 2'b00, '0, 0, 0, 2'd3, '0);
            step("R7 nested entry", 1, AW'(200 - st * 8 - xv), 0, 0, 2'b00, '0, 0, 0, 2'd3, '0);
            step("R8 return redirect", 0, '0, 1, 0, 2'b00, '0, 0, 0, 2'd3, '0);
            // R3: clean entry and return restores the starting state
            mtmsr("R4 reload", st[1:0], xv[XB-1:0]);
            step("R3 entry", 1, AW'(st + xv * 64), 0, 0, 2'b00, '0, 0, 0, 2'd3, '0);
            step("R3 return restore", 0, '0, 1, 0, 2'b00, '0, 0, 0, 2'd3, '0);
         end
      end

      // R9: every combination of the four competing strobes
      for (int k = 0; k < 16; k++) begin
         mtmsr("R9 prep", 2'b10, 2'b01);
         step("R9 prep entry", 1, AW'(k * 11 + 1), 0, 0, 2'b00, '0, 0, 0, 2'd3, '0);
         mtmsr("R9 prep live", k[1:0] ^ 2'b11, k[3:2]);
         step("R9 priority", k[0], AW'(k * 7 + 2), k[1], k[2], 2'b01, 2'b10,
              k[3], 0, 2'd0, DW'(k));
      end

      do_reset();
      finish_run();
   end

endmodule